// File: doc/BRIEF.md
# Configurable Byte-Order Load/Store Aligner

This block sits between the load/store pipeline of a processor and a 64-bit data memory port. For each access it decides the byte order from four sources. Two come from the processor state: a global mode and a mode used while the processor is in trap handling. One is an attribute carried by the instruction that requests little-endian. The last is an attribute returned by the page translation that flips the order. The block then steers store bytes onto the addressed memory lanes and drives byte enables. For loads, it pulls bytes from the lanes of the returned memory word and sign- or zero-extends the value.

Each access is presented with `in_valid` together with all of its attributes. For a load, the memory word is presented in the same cycle on `mem_rdata`. The result appears one cycle later with `out_valid`. There is no back-pressure in either direction, because the pipeline slot it serves never stalls. An access may be presented on every cycle, and each result is valid for exactly one cycle. If an access's offset is not a multiple of its size, it is flagged and produces no byte enables.

Top module: `endian_aligner`

## Requirements
- R1: While `rst_n` is low, and on the first sampling after it is released, `out_valid`, `byte_en`, `wr_data`, `rd_result` and `align_err` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. All results are registered with exactly one cycle of latency.
- R3: The base order is taken from `trap_le` when `in_trap` is 1, and from `global_le` otherwise. A value of 1 means little-endian.
- R4: `asi_le` = 1 makes the order little-endian, whatever the base order is.
- R5: `page_flip` = 1 inverts the order produced by R3 and R4.
- R6: `access_size` encodes 0=1, 1=2, 2=4 and 3=8 bytes. A 1-byte access gives the same data for either byte order.
- R7: For an aligned store of N bytes at offset o, memory byte o+i uses lane bits [8(o+i)+7 : 8(o+i)]. In little-endian order it carries value byte i of `st_data`; in big-endian order it carries value byte N-1-i. `byte_en` is high on exactly lanes o..o+N-1. All other lanes of `wr_data` are zero.
- R8: For an aligned load, value byte j is taken from lane o+j in little-endian order and from lane o+N-1-j in big-endian order. Loads also drive `byte_en` on their lanes, and `wr_data` is zero for a load.
- R9: When `signed_ld` is 1, bits above the loaded value copy its top bit; when it is 0, they are zero. `rd_result` is zero for a store.
- R10: If `addr_off` is not a multiple of the size, `align_err` is 1 and `byte_en`, `wr_data` and `rd_result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access presented this cycle |
| is_store | input | 1 | 1 = store, 0 = load |
| access_size | input | 2 | Size code (R6) |
| addr_off | input | 3 | Byte offset within the 64-bit word |
| global_le | input | 1 | Global mode, 1 = little-endian |
| trap_le | input | 1 | Trap-handler mode, 1 = little-endian |
| in_trap | input | 1 | Processor is in trap handling |
| asi_le | input | 1 | Instruction attribute forcing little-endian |
| page_flip | input | 1 | Page attribute inverting the order |
| signed_ld | input | 1 | Sign-extend the load result |
| st_data | input | 64 | Store value, right-justified |
| mem_rdata | input | 64 | Memory word for a load |
| out_valid | output | 1 | Result valid |
| wr_data | output | 64 | Lane-placed store data |
| byte_en | output | 8 | Lane enables |
| rd_result | output | 64 | Extended load value |
| align_err | output | 1 | Misaligned access |

## Verification
If the block resolved the order incorrectly, the error would show at the ports one cycle after the access: reversed bytes in `wr_data` or `rd_result` for any multi-byte access. Single-byte accesses would be unaffected, which is why the bench crosses every order source with sizes 2, 4 and 8. A wrong lane or wrong enable state shows up as a `byte_en` pattern with the wrong population or position on the very next cycle. A stale output register shows up as `out_valid` or data that persists into an idle cycle. The bench compares every output against a behavioural model on every clock, so any of these faults is reported in the cycle it first appears.

// File: rtl/endian_aligner_pkg.sv
package endian_aligner_pkg;
  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } acc_size_e;

  function automatic int size_to_bytes(input logic [1:0] code);
    return 1 << code;
  endfunction
endpackage

// File: rtl/byte_order_resolve.sv
module byte_order_resolve (
  input  logic global_le,
  input  logic trap_le,
  input  logic in_trap,
  input  logic asi_le,
  input  logic page_flip,
  output logic eff_le
);
  logic base_le;
  logic req_le;

  always_comb begin
    base_le = in_trap ? trap_le : global_le;
    req_le  = base_le | asi_le;
    eff_le  = req_le ^ page_flip;
  end
endmodule

// File: rtl/store_lane_place.sv
module store_lane_place #(
  parameter int NB     = 8,
  parameter int OFF_W  = 3,
  parameter int SIZE_W = 2
) (
  input  logic [8*NB-1:0]   data,
  input  logic [SIZE_W-1:0] size,
  input  logic [OFF_W-1:0]  offset,
  input  logic              le,
  input  logic              kill,
  output logic [8*NB-1:0]   wdata,
  output logic [NB-1:0]     be
);
  always_comb begin
    int n;
    int rel;
    int idx;
    n     = 1 << size;
    wdata = '0;
    be    = '0;
    for (int k = 0; k < NB; k++) begin
      rel = k - int'(offset);
      idx = 0;
      if (!kill && rel >= 0 && rel < n) begin
        be[k] = 1'b1;
        idx   = le ? rel : (n - 1 - rel);
        wdata[8*k +: 8] = data[8*idx +: 8];
      end
    end
  end
endmodule

// File: rtl/load_lane_gather.sv
module load_lane_gather #(
  parameter int NB     = 8,
  parameter int OFF_W  = 3,
  parameter int SIZE_W = 2
) (
  input  logic [8*NB-1:0]   raw,
  input  logic [SIZE_W-1:0] size,
  input  logic [OFF_W-1:0]  offset,
  input  logic              le,
  input  logic              sign_ext,
  input  logic              kill,
  output logic [8*NB-1:0]   result
);
  logic [8*NB-1:0] picked;
  logic            fill_bit;

  always_comb begin
    int n;
    int lane;
    n      = 1 << size;
    picked = '0;
    for (int j = 0; j < NB; j++) begin
      lane = le ? (int'(offset) + j) : (int'(offset) + n - 1 - j);
      if (j < n && lane >= 0 && lane < NB)
        picked[8*j +: 8] = raw[8*lane +: 8];
    end
    fill_bit = sign_ext & picked[8*n-1];
    result   = picked;
    for (int j = 0; j < NB; j++) begin
      if (j >= n) result[8*j +: 8] = {8{fill_bit}};
    end
    if (kill) result = '0;
  end
endmodule

// File: rtl/endian_aligner.sv
module endian_aligner #(
  parameter int DATA_W = 64,
  localparam int NB     = DATA_W / 8,
  localparam int OFF_W  = $clog2(NB),
  localparam int SIZE_W = $clog2(OFF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              is_store,
  input  logic [SIZE_W-1:0] access_size,
  input  logic [OFF_W-1:0]  addr_off,
  input  logic              global_le,
  input  logic              trap_le,
  input  logic              in_trap,
  input  logic              asi_le,
  input  logic              page_flip,
  input  logic              signed_ld,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic [NB-1:0]     byte_en,
  output logic [DATA_W-1:0] rd_result,
  output logic              align_err
);
  import endian_aligner_pkg::*;

  logic              eff_le;
  logic              misalign;
  logic [OFF_W-1:0]  off_mask;
  logic [DATA_W-1:0] placed;
  logic [NB-1:0]     lane_en;
  logic [DATA_W-1:0] loaded;

  byte_order_resolve u_order (
    .global_le (global_le),
    .trap_le   (trap_le),
    .in_trap   (in_trap),
    .asi_le    (asi_le),
    .page_flip (page_flip),
    .eff_le    (eff_le)
  );

  always_comb begin
    off_mask = OFF_W'(size_to_bytes(2'(access_size)) - 1);
    misalign = (addr_off & off_mask) != '0;
  end

  store_lane_place #(.NB(NB), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_store (
    .data   (st_data),
    .size   (access_size),
    .offset (addr_off),
    .le     (eff_le),
    .kill   (misalign),
    .wdata  (placed),
    .be     (lane_en)
  );

  load_lane_gather #(.NB(NB), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_load (
    .raw      (mem_rdata),
    .size     (access_size),
    .offset   (addr_off),
    .le       (eff_le),
    .sign_ext (signed_ld),
    .kill     (misalign),
    .result   (loaded)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_data   <= '0;
      byte_en   <= '0;
      rd_result <= '0;
      align_err <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wr_data   <= is_store ? placed : '0;
        rd_result <= is_store ? '0 : loaded;
        byte_en   <= lane_en;
        align_err <= misalign;
      end else begin
        wr_data   <= '0;
        rd_result <= '0;
        byte_en   <= '0;
        align_err <= 1'b0;
      end
    end
  end

  // R2: one-cycle valid pipeline
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7: enable population matches access size
  p_be_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !align_err) |->
      ($countones(byte_en) == size_to_bytes(2'($past(access_size)))));
  // R10: misaligned access drives nothing
  p_err_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && align_err) |-> (byte_en == '0 && rd_result == '0 && wr_data == '0));
  // R6: single-byte store lands unchanged on its lane
  p_byte_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(is_store) && $past(access_size) == '0) |->
      (wr_data == (DATA_W'($past(st_data[7:0])) << (8 * $past(addr_off)))));
  // R6: single-byte access enables one lane
  p_byte_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(access_size) == '0) |-> $onehot(byte_en));
endmodule

// File: tb/endian_aligner_tb_top.sv
`timescale 1ns/1ps
module endian_aligner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, is_store = 1'b0;
  logic [1:0]  access_size = '0;
  logic [2:0]  addr_off = '0;
  logic        global_le = 1'b0, trap_le = 1'b0, in_trap = 1'b0;
  logic        asi_le = 1'b0, page_flip = 1'b0, signed_ld = 1'b0;
  logic [63:0] st_data = '0, mem_rdata = '0;
  logic        out_valid, align_err;
  logic [63:0] wr_data, rd_result;
  logic [7:0]  byte_en;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic        e_valid, e_err;
  logic [7:0]  e_be;
  logic [63:0] e_wr, e_rd;

  always #4 clk = ~clk;

  endian_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_store(is_store),
    .access_size(access_size), .addr_off(addr_off), .global_le(global_le),
    .trap_le(trap_le), .in_trap(in_trap), .asi_le(asi_le), .page_flip(page_flip),
    .signed_ld(signed_ld), .st_data(st_data), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .wr_data(wr_data), .byte_en(byte_en),
    .rd_result(rd_result), .align_err(align_err)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: byte arrays, address-ordered
  task automatic model(input bit v, input bit st, input int sz, input int off,
                       input bit g, input bit t, input bit tr, input bit a, input bit p,
                       input bit sg, input logic [63:0] sd, input logic [63:0] raw);
    byte unsigned val[8];
    byte unsigned mem[8];
    int n;
    bit le;
    bit neg;
    n  = 1 << sz;
    le = tr ? t : g;
    if (a) le = 1;
    le = le ^ p;
    e_valid = v; e_err = 0; e_be = '0; e_wr = '0; e_rd = '0;
    if (!v) return;
    if (off % n != 0) begin e_err = 1; return; end
    for (int i = 0; i < 8; i++) begin val[i] = sd[8*i +: 8]; mem[i] = raw[8*i +: 8]; end
    for (int i = 0; i < n; i++) begin
      e_be[off+i] = 1'b1;
      if (st) e_wr[8*(off+i) +: 8] = le ? val[i] : val[n-1-i];
    end
    if (!st) begin
      for (int i = 0; i < n; i++) e_rd[8*i +: 8] = le ? mem[off+i] : mem[off+n-1-i];
      neg = sg && e_rd[8*n-1];
      for (int i = n; i < 8; i++) e_rd[8*i +: 8] = neg ? 8'hFF : 8'h00;
    end
  endtask

  task automatic step(input string tag, input bit v, input bit st, input int sz, input int off,
                      input bit g, input bit t, input bit tr, input bit a, input bit p,
                      input bit sg, input logic [63:0] sd, input logic [63:0] raw);
    in_valid = v; is_store = st; access_size = 2'(sz); addr_off = 3'(off);
    global_le = g; trap_le = t; in_trap = tr; asi_le = a; page_flip = p;
    signed_ld = sg; st_data = sd; mem_rdata = raw;
    model(v, st, sz, off, g, t, tr, a, p, sg, sd, raw);
    @(negedge clk);
    chk("R2", "out_valid", 64'(out_valid), 64'(e_valid));
    if (e_valid) begin
      chk("R10", "align_err", 64'(align_err), 64'(e_err));
      chk(tag, "byte_en", 64'(byte_en), 64'(e_be));
      chk(tag, "wr_data", wr_data, e_wr);
      chk(tag, "rd_result", rd_result, e_rd);
    end
  endtask

  localparam logic [63:0] RAW = 64'h8877_6655_4433_2211;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
    chk("R1", "byte_en in reset", 64'(byte_en), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "wr_data after reset", wr_data, 64'd0);
    chk("R1", "rd_result after reset", rd_result, 64'd0);

    // R6: single byte, both orders
    step("R6", 1,1,0,5, 0,0,0,0,0, 0, 64'hAB, 0);
    chk("R6", "byte big", wr_data, 64'h0000_AB00_0000_0000);
    step("R6", 1,1,0,5, 1,0,0,0,0, 0, 64'hAB, 0);
    chk("R6", "byte little", wr_data, 64'h0000_AB00_0000_0000);
    // R3: global vs trap
    step("R3", 1,1,2,4, 0,1,0,0,0, 0, 64'h1122_3344, 0);
    chk("R3", "global big", wr_data, 64'h4433_2211_0000_0000);
    step("R3", 1,1,2,4, 0,1,1,0,0, 0, 64'h1122_3344, 0);
    chk("R3", "trap little", wr_data, 64'h1122_3344_0000_0000);
    step("R3", 1,1,2,4, 1,0,1,0,0, 0, 64'h1122_3344, 0);
    chk("R3", "trap big over global", wr_data, 64'h4433_2211_0000_0000);
    // R4: attribute forces little
    step("R4", 1,1,2,0, 0,0,0,1,0, 0, 64'h1122_3344, 0);
    chk("R4", "asi little", wr_data, 64'h0000_0000_1122_3344);
    // R5: page flip
    step("R5", 1,1,2,0, 0,0,0,0,1, 0, 64'h1122_3344, 0);
    chk("R5", "flip to little", wr_data, 64'h0000_0000_1122_3344);
    step("R5", 1,1,2,0, 0,0,0,1,1, 0, 64'h1122_3344, 0);
    chk("R5", "flip asi to big", wr_data, 64'h0000_0000_4433_2211);
    // R7: full width
    step("R7", 1,1,3,0, 0,0,0,0,0, 0, 64'h0102_0304_0506_0708, 0);
    chk("R7", "8B big", wr_data, 64'h0807_0605_0403_0201);
    chk("R7", "8B enables", 64'(byte_en), 64'hFF);
    // R8: halfword loads
    step("R8", 1,0,1,2, 0,0,0,0,0, 0, 0, RAW);
    chk("R8", "half big", rd_result, 64'h3344);
    chk("R8", "load wr_data", wr_data, 64'd0);
    step("R8", 1,0,1,2, 1,0,0,0,0, 0, 0, RAW);
    chk("R8", "half little", rd_result, 64'h4433);
    // R9: extension
    step("R9", 1,0,0,7, 0,0,0,0,0, 1, 0, RAW);
    chk("R9", "signed byte", rd_result, 64'hFFFF_FFFF_FFFF_FF88);
    step("R9", 1,0,0,7, 0,0,0,0,0, 0, 0, RAW);
    chk("R9", "unsigned byte", rd_result, 64'h88);
    step("R9", 1,0,1,6, 0,0,0,0,0, 1, 0, RAW);
    chk("R9", "signed half big", rd_result, 64'h7788);
    step("R9", 1,0,1,6, 1,0,0,0,0, 1, 0, RAW);
    chk("R9", "signed half little", rd_result, 64'hFFFF_FFFF_FFFF_8877);
    // R10: misaligned
    step("R10", 1,1,2,2, 0,0,0,0,0, 0, 64'h1122_3344, 0);
    chk("R10", "misaligned err", 64'(align_err), 64'd1);
    chk("R10", "misaligned be", 64'(byte_en), 64'd0);
    step("R10", 1,0,3,4, 0,0,0,0,0, 1, 0, RAW);
    chk("R10", "misaligned load", rd_result, 64'd0);
    // R2: idle cycle
    step("R2", 0,0,0,0, 0,0,0,0,0, 0, 0, 0);
    chk("R2", "idle be", 64'(byte_en), 64'd0);

    // Mixed stream against the model, every clock (R7, R8)
    for (int k = 0; k < 400; k++) begin
      automatic int r = $urandom;
      automatic int sz = $urandom_range(0, 3);
      automatic int off = ($urandom_range(0, 9) < 8) ? ($urandom_range(0, 7) & ~((1 << sz) - 1))
                                                     : $urandom_range(0, 7);
      step((r & 2) ? "R7" : "R8", (r & 1) == 0 || (r & 64) != 0, (r & 2) != 0, sz, off,
           r[2], r[3], r[4], r[5], r[6], r[7], {$urandom, $urandom}, {$urandom, $urandom});
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule